// File: doc/BRIEF.md
# RS-485 UART Transmitter with Automatic Direction Control

This block serialises bytes into 8N1 frames and drives the direction pins of a half-duplex RS-485 transceiver by itself. Bytes enter through a plain valid/data write port. They are queued either in a 16-entry FIFO or, with the FIFO switched off, in a single holding slot. A ten-bit shift register then sends each byte at one bit per sixteen baud ticks.

The direction logic turns the driver on one full bit time before the first start bit, so the bus settles at the idle-high level first. It keeps the driver on while further bytes are queued, and turns it off on the very clock on which the stop bit of the last queued byte ends. Software never has to guess when the final bit has left the wire. Status outputs report an empty queue, an active frame, full transmitter idleness and a sticky overflow.

Top module: `uart485_tx`

## Requirements
- R1: After reset, txOut is 1, drvEn is 0, rxEnN is 0, txEmpty is 1, txIdle is 1, and busy and overflow are 0.
- R2: Each byte is sent as one start bit at 0, then eight data bits with the least significant bit first, then one stop bit at 1. Each bit lasts 16 baud ticks.
- R3: drvEn rises, and rxEnN rises with it, exactly 16 baud ticks before the leading edge of the start bit of a frame that follows an idle bus. txOut stays 1 during those ticks.
- R4: When nothing is queued at the end of a stop bit, drvEn and rxEnN fall on that same clock. They stay high up to and including the last cycle of the stop bit.
- R5: With fifoEn at 1, txEmpty is 1 exactly when the FIFO holds no byte. With fifoEn at 0, txEmpty is 1 exactly when the holding slot is empty. In both modes txEmpty ignores a byte that is still in the shift register.
- R6: busy is 1 from the first cycle of the start bit through the last cycle of the stop bit, and 0 otherwise.
- R7: txIdle is 1 only when no byte is queued, no frame is being sent and no pre-start settle period is running.
- R8: The queue holds 16 bytes with fifoEn at 1 and 1 byte with fifoEn at 0. A write to a full queue is dropped and sets overflow, which then stays 1 until reset.
- R9: A byte that is queued before the end of a stop bit starts its frame on the next tick, back to back. drvEn stays high in between and no settle period is inserted.
- R10: A write in the same cycle in which a queued byte moves into the shift register is accepted even if the queue was full, because that move frees one place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baudTick | input | 1 | One-cycle pulse, 16 per bit time |
| fifoEn | input | 1 | 1 selects the 16-byte FIFO, 0 selects the single holding slot |
| wrEn | input | 1 | Byte write strobe |
| wrData | input | 8 | Byte to queue |
| txOut | output | 1 | Serial line to the transceiver |
| drvEn | output | 1 | Transceiver driver enable |
| rxEnN | output | 1 | Transceiver receive enable, active low |
| txEmpty | output | 1 | Selected queue is empty |
| busy | output | 1 | A frame is on the wire |
| txIdle | output | 1 | Nothing queued and nothing being sent |
| overflow | output | 1 | Sticky flag for a dropped write |

## Verification
A host write and the transfer of a queued byte into the shift register can land on the same clock. The bench provokes this in holding-slot mode: it waits until a byte is held behind a running frame, then counts cycles from the observed start edge and writes on the exact clock on which that frame's stop bit ends. The write is judged correct if the third byte is sent after the second with no gap and overflow stays 0. A design that compares against the full level before the transfer would drop the byte and raise overflow.

// File: rtl/uart485_pkg.sv
package uart485_pkg;
  typedef struct packed {
    logic load;   // pop the queue head into the shift register
    logic shift;  // advance the shift register by one bit
  } txStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SEND
  } txState_t;
endpackage

// File: rtl/tx_datapath.sv
module tx_datapath
  import uart485_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  txStrobe_t         strobe,
  output logic              txLine,
  output logic              queueEmpty,
  output logic              overflow
);
  localparam int AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW      = $clog2(DEPTH + 1);
  localparam int FRAME_W = DATA_W + 2;

  logic [DATA_W-1:0]  mem [DEPTH];
  logic [AW-1:0]      rdPtr, wrPtr;
  logic [CW-1:0]      count, cap;
  logic [FRAME_W-1:0] shiftReg;
  logic               accept;

  // Bypass mode limits the same storage to one entry: the holding slot.
  assign cap    = fifoEn ? CW'(DEPTH) : CW'(1);
  assign accept = wrEn && ((count < cap) || strobe.load);

  always_ff @(posedge clk) begin
    if (accept) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr    <= '0;
      wrPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (accept) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (strobe.load) rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      if (accept && !strobe.load) count <= count + 1'b1;
      else if (!accept && strobe.load) count <= count - 1'b1;
      if (wrEn && !accept) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '1;
    else if (strobe.load) shiftReg <= {1'b1, mem[rdPtr], 1'b0};
    else if (strobe.shift) shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
  end

  assign txLine     = shiftReg[0];
  assign queueEmpty = (count == '0);

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow); // R8
  AST_FILL_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH)); // R8
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> count != '0); // R9
endmodule

// File: rtl/tx_control.sv
module tx_control
  import uart485_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16,
  parameter int SETUP_BITS    = 1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      baudTick,
  input  logic      queueEmpty,
  input  logic      txLine,
  output txStrobe_t strobe,
  output logic      drvEn,
  output logic      busy,
  output logic      txIdle
);
  localparam int FRAME_BITS  = DATA_W + 2;
  localparam int BW          = $clog2(FRAME_BITS);
  localparam int SETUP_TICKS = TICKS_PER_BIT * SETUP_BITS;
  localparam int TW          = (SETUP_TICKS > 1) ? $clog2(SETUP_TICKS) : 1;

  txState_t      state, stateNext;
  logic [TW-1:0] tickCnt, tickNext;
  logic [BW-1:0] bitCnt, bitNext;
  logic          lastTick;

  assign lastTick = baudTick &&
    (tickCnt == ((state == ST_SETUP) ? TW'(SETUP_TICKS - 1) : TW'(TICKS_PER_BIT - 1)));

  always_comb begin
    stateNext = state;
    tickNext  = tickCnt;
    bitNext   = bitCnt;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (!queueEmpty) begin
          stateNext = ST_SETUP;
          tickNext  = '0;
        end
      end
      ST_SETUP: begin
        if (lastTick) begin
          stateNext   = ST_SEND;
          strobe.load = 1'b1;
          tickNext    = '0;
          bitNext     = '0;
        end else if (baudTick) begin
          tickNext = tickCnt + 1'b1;
        end
      end
      ST_SEND: begin
        if (lastTick) begin
          tickNext = '0;
          if (bitCnt == BW'(FRAME_BITS - 1)) begin
            bitNext = '0;
            if (!queueEmpty) strobe.load = 1'b1;
            else stateNext = ST_IDLE;
          end else begin
            strobe.shift = 1'b1;
            bitNext      = bitCnt + 1'b1;
          end
        end else if (baudTick) begin
          tickNext = tickCnt + 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else begin
      state   <= stateNext;
      tickCnt <= tickNext;
      bitCnt  <= bitNext;
    end
  end

  assign drvEn  = (state != ST_IDLE);
  assign busy   = (state == ST_SEND);
  assign txIdle = (state == ST_IDLE) && queueEmpty;

  AST_LINE_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txLine); // R3
  AST_DE_BEFORE_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(drvEn)); // R3
  AST_RELEASE_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(drvEn) |-> (queueEmpty && txLine)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    txIdle |-> (txLine && !drvEn)); // R7
endmodule

// File: rtl/uart485_tx.sv
module uart485_tx
  import uart485_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int FIFO_DEPTH    = 16,
  parameter int TICKS_PER_BIT = 16,
  parameter int SETUP_BITS    = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              fifoEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              txOut,
  output logic              drvEn,
  output logic              rxEnN,
  output logic              txEmpty,
  output logic              busy,
  output logic              txIdle,
  output logic              overflow
);
  txStrobe_t strobe;
  logic      queueEmpty;

  tx_datapath #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .wrEn(wrEn), .wrData(wrData),
    .strobe(strobe), .txLine(txOut), .queueEmpty(queueEmpty), .overflow(overflow)
  );

  tx_control #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT), .SETUP_BITS(SETUP_BITS)) u_ctl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .queueEmpty(queueEmpty),
    .txLine(txOut), .strobe(strobe), .drvEn(drvEn), .busy(busy), .txIdle(txIdle)
  );

  // Receive is enabled (low) exactly while the driver is off.
  assign rxEnN   = drvEn;
  assign txEmpty = queueEmpty;
endmodule

// File: tb/uart485_tx_tb.sv
module uart485_tx_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b1;
  logic       fifoEn = 1'b1;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       txOut, drvEn, rxEnN, txEmpty, busy, txIdle, overflow;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  uart485_tx u_dut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .fifoEn(fifoEn), .wrEn(wrEn),
    .wrData(wrData), .txOut(txOut), .drvEn(drvEn), .rxEnN(rxEnN), .txEmpty(txEmpty),
    .busy(busy), .txIdle(txIdle), .overflow(overflow)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    wrEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic putByte(input logic [7:0] b);
    wrEn   = 1'b1;
    wrData = b;
    @(negedge clk);
    wrEn   = 1'b0;
  endtask

  // Waits for a start edge, then samples each bit in its middle.
  // Returns at the middle of the stop bit.
  task automatic getFrame(output logic [7:0] b, output int waited, output int deCnt,
                          output bit deGap, output bit shapeOk);
    waited = 0; deCnt = 0; deGap = 1'b0; shapeOk = 1'b1;
    while (txOut) begin
      if (drvEn && rxEnN) deCnt++;
      else deGap = 1'b1;
      @(negedge clk);
      waited++;
    end
    repeat (8) @(negedge clk);
    if (txOut !== 1'b0 || busy !== 1'b1) shapeOk = 1'b0;
    for (int k = 0; k < 8; k++) begin
      repeat (16) @(negedge clk);
      b[k] = txOut;
    end
    repeat (16) @(negedge clk);
    if (txOut !== 1'b1 || busy !== 1'b1) shapeOk = 1'b0;
  endtask

  task automatic t_reset();
    doReset();
    check(txOut === 1'b1, "R1 txOut", txOut, 1);
    check(drvEn === 1'b0 && rxEnN === 1'b0, "R1 direction", {drvEn, rxEnN}, 0);
    check(txEmpty === 1'b1 && txIdle === 1'b1, "R1 empty/idle", {txEmpty, txIdle}, 3);
    check(busy === 1'b0 && overflow === 1'b0, "R1 busy/overflow", {busy, overflow}, 0);
  endtask

  task automatic t_single(input bit fen, input logic [7:0] v);
    logic [7:0] b; int w, de; bit gap, ok;
    doReset();
    fifoEn = fen;
    putByte(v);
    getFrame(b, w, de, gap, ok);
    check(b == v, "R2 data LSB first", b, v);
    check(ok, "R2 start/stop shape", ok, 1);
    check(de == 16, "R3 driver lead ticks", de, 16);
    repeat (7) @(negedge clk);
    check(drvEn === 1'b1 && busy === 1'b1, "R4 held to end of stop", {drvEn, busy}, 3);
    @(negedge clk);
    check(drvEn === 1'b0 && rxEnN === 1'b0, "R4 released after stop", {drvEn, rxEnN}, 0);
    check(busy === 1'b0, "R6 busy low after frame", busy, 0);
    check(txIdle === 1'b1 && txOut === 1'b1, "R7 idle after frame", {txIdle, txOut}, 3);
  endtask

  task automatic t_emptyMeaning(input bit fen);
    logic [7:0] b; int w, de; bit gap, ok;
    doReset();
    fifoEn = fen;
    check(txEmpty === 1'b1, "R5 empty before write", txEmpty, 1);
    putByte(8'h5A);
    check(txEmpty === 1'b0, "R5 not empty when queued", txEmpty, 0);
    check(txIdle === 1'b0 && busy === 1'b0, "R7 not idle during setup", {txIdle, busy}, 0);
    getFrame(b, w, de, gap, ok);
    check(txEmpty === 1'b1 && busy === 1'b1, "R5 empty while shifting", {txEmpty, busy}, 3);
    check(txIdle === 1'b0, "R7 not idle while shifting", txIdle, 0);
    check(b == 8'h5A, "R2 data", b, 8'h5A);
    repeat (20) @(negedge clk);
  endtask

  task automatic t_burst();
    logic [7:0] b; int w, de; bit gap, ok;
    logic [7:0] v [3] = '{8'hC3, 8'h01, 8'hFE};
    doReset();
    fifoEn = 1'b1;
    for (int i = 0; i < 3; i++) putByte(v[i]);
    for (int i = 0; i < 3; i++) begin
      getFrame(b, w, de, gap, ok);
      check(b == v[i] && ok, "R9 burst data", b, v[i]);
      if (i > 0) begin
        check(w == 8, "R9 back-to-back gap", w, 8);
        check(!gap, "R9 driver held between frames", gap, 0);
      end
    end
    repeat (8) @(negedge clk);
    check(drvEn === 1'b0 && txIdle === 1'b1, "R4 release after burst", {drvEn, txIdle}, 1);
  endtask

  task automatic t_overflowFifo();
    logic [7:0] b; int w, de; bit gap, ok;
    doReset();
    fifoEn = 1'b1;
    for (int i = 0; i < 17; i++) putByte(8'h10 + 8'(i));
    check(overflow === 1'b1, "R8 overflow on 17th write", overflow, 1);
    for (int i = 0; i < 16; i++) begin
      getFrame(b, w, de, gap, ok);
      check(b == 8'h10 + 8'(i), "R8 fifo order", b, 8'h10 + i);
    end
    repeat (40) @(negedge clk);
    check(txIdle === 1'b1 && txOut === 1'b1, "R8 dropped byte never sent", {txIdle, txOut}, 3);
    check(overflow === 1'b1, "R8 overflow sticky", overflow, 1);
  endtask

  task automatic t_bypassDrop();
    logic [7:0] b; int w, de; bit gap, ok;
    doReset();
    fifoEn = 1'b0;
    putByte(8'hA1);
    putByte(8'hB2);
    check(overflow === 1'b1, "R8 holding slot full", overflow, 1);
    getFrame(b, w, de, gap, ok);
    check(b == 8'hA1, "R8 held byte sent", b, 8'hA1);
    repeat (40) @(negedge clk);
    check(txIdle === 1'b1, "R8 second byte dropped", txIdle, 1);
  endtask

  task automatic t_sameCycle();
    logic [7:0] b; int w, de; bit gap, ok;
    doReset();
    fifoEn = 1'b0;
    putByte(8'h3C);
    getFrame(b, w, de, gap, ok);        // middle of stop bit of first frame
    putByte(8'h96);                     // holding slot now full
    repeat (6) @(negedge clk);          // one cycle before the stop bit ends
    putByte(8'h69);                     // lands on the transfer clock
    check(overflow === 1'b0, "R10 write accepted on transfer", overflow, 0);
    getFrame(b, w, de, gap, ok);
    check(b == 8'h96 && w == 0, "R9 second frame back to back", b, 8'h96);
    getFrame(b, w, de, gap, ok);
    check(b == 8'h69, "R10 third byte sent", b, 8'h69);
    check(w == 8 && !gap, "R10 third frame contiguous", w, 8);
  endtask

  initial begin
    t_reset();
    t_single(1'b1, 8'hA5);
    t_single(1'b0, 8'h81);
    t_emptyMeaning(1'b1);
    t_emptyMeaning(1'b0);
    t_burst();
    t_bypassDrop();
    t_sameCycle();
    t_overflowFifo();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule